// File: doc/BRIEF.md
# USB Device Suspend and Wake-Up Sequencer

This block controls how a full-speed USB device controller goes into suspend and how it comes back out. It runs on an always-on reference clock and receives a one-cycle pulse once every millisecond. When the bus-idle detector reports suspend, the block turns off the oscillator and the core clock. It also lowers an active-low suspend pin and tri-states selected host-side pins, according to two configuration bits.

Three sources can start a wake-up: the host driving a K state, the application pulling the remote-wakeup pin low, or firmware writing the soft-reset bit while the feature-enable bit is 1. On a wake-up the block first restarts the oscillator. It keeps the core clock off for a programmable settling time. It then sets a sticky resume flag, and optionally an interrupt. After a remote wake-up it also asks the transceiver to drive K for a fixed time.

While the block is suspended, firmware register writes and reads that have side effects are blocked.

Top module: `susp_seq`

## Requirements
- R1: While awake with the resume flag clear, `bus_suspend`=1 makes `susp_n`, `osc_en` and `core_clk_en` all 0 after the next clock edge.
- R2: While suspended, any one of `host_k`=1, `rwake_n`=0, or `fw_srst_wr`=1 with `fw_feat_en`=1 raises `susp_n` and `osc_en` after the next edge, with `core_clk_en` still 0. `fw_srst_wr` with `fw_feat_en`=0 leaves the block suspended.
- R3: `core_clk_en` returns on the edge that takes the S-th `tick_ms` pulse after the wake edge. S is `cfg_stab_ms` limited to the range 6 to 15.
- R4: On that same edge `resume_flag` becomes 1. `resume_irq` equals `resume_flag` AND `cfg_irq_en`.
- R5: After a remote wake-up, `drive_k` is 1 for exactly 12 tick pulses. It rises no sooner than the 7th tick after the wake edge. When S is 6, one extra tick passes with `drive_k`=0 before it rises.
- R6: Wake priority is host K, then remote pin, then firmware. Only a wake-up won by the remote pin ever raises `drive_k`.
- R7: `resume_flag` stays 1 until `fw_clr_resume` is pulsed while not suspended. While it is 1, `bus_suspend` does not suspend the block.
- R8: `wr_grant` follows `fw_wr` and `rd_grant` follows `fw_rd_side` except while suspended, when both are 0.
- R9: `grpa_oe` (data bus, interrupt, frame-marker pins) is 0 exactly when the block is suspended and `cfg_susp_pwroff`=1.
- R10: `grpb_oe` (USB-reset and address-strobe pins) is 0 exactly when the block is suspended and `cfg_board_feat`=0.
- R11: After synchronous reset, `susp_n`, `osc_en`, `core_clk_en`, `grpa_oe` and `grpb_oe` are 1, and `resume_flag`, `resume_irq` and `drive_k` are 0.
- R12: `bus_suspend` has no effect while a wake-up sequence is in progress. The settling count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| bus_suspend | input | 1 | Bus-idle suspend detected |
| host_k | input | 1 | Host resume (K state) detected |
| rwake_n | input | 1 | Active-low remote wake-up request |
| fw_wr | input | 1 | Firmware register write strobe |
| fw_rd_side | input | 1 | Firmware read-with-side-effect strobe |
| fw_srst_wr | input | 1 | Firmware writes 1 to the soft-reset bit |
| fw_feat_en | input | 1 | Feature-enable bit that gates firmware wake |
| fw_clr_resume | input | 1 | Firmware clears the resume flag |
| cfg_stab_ms | input | 4 | Settling time in ms (limited to 6..15) |
| cfg_irq_en | input | 1 | Resume interrupt enable |
| cfg_susp_pwroff | input | 1 | Tri-state group A while suspended |
| cfg_board_feat | input | 1 | When 0, tri-state group B while suspended |
| susp_n | output | 1 | Active-low suspend pin |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| resume_flag | output | 1 | Sticky resume status |
| resume_irq | output | 1 | Resume interrupt |
| drive_k | output | 1 | Request to drive K on the bus |
| wr_grant | output | 1 | Register write allowed |
| rd_grant | output | 1 | Side-effect read allowed |
| grpa_oe | output | 1 | Output enable, data/interrupt/frame pins |
| grpb_oe | output | 1 | Output enable, USB-reset/address-strobe pins |

## Verification
The bench builds the block with its default parameter values: a 6 to 15 ms settling window, 12 ms of K, and a 7 ms minimum before K. The bench drives `tick_ms` itself as a single-cycle pulse, so each millisecond costs only a few clock cycles, and every tick count can be checked on the exact edge where it takes effect. Programming 3 or 0 reaches the lower limit, and 15 reaches the upper limit. Programming 6 after a remote wake-up reaches the extra hold tick, while 7 goes straight to driving K.

// File: rtl/susp_seq_pkg.sv
package susp_seq_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE,
        ST_SUSP,
        ST_STAB,
        ST_KHOLD,
        ST_DRIVEK
    } seq_state_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_HOST,
        WK_REMOTE,
        WK_FW
    } wake_src_e;

    typedef struct packed {
        logic host;
        logic remote;
        logic fw;
    } wake_req_t;

    function automatic int unsigned clamp_ms(input int unsigned v,
                                             input int unsigned lo,
                                             input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/susp_wake_arb.sv
module susp_wake_arb
    import susp_seq_pkg::*;
(
    input  wake_req_t req,
    output wake_src_e src
);
    always_comb begin
        if (req.host)        src = WK_HOST;
        else if (req.remote) src = WK_REMOTE;
        else if (req.fw)     src = WK_FW;
        else                 src = WK_NONE;
    end
endmodule

// File: rtl/susp_ms_timer.sv
module susp_ms_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_nxt
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_nxt = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr)      cnt_q <= '0;
        else if (en && tick) cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/susp_pin_gate.sv
module susp_pin_gate (
    input  logic suspended,
    input  logic fw_wr,
    input  logic fw_rd_side,
    input  logic cfg_susp_pwroff,
    input  logic cfg_board_feat,
    output logic wr_grant,
    output logic rd_grant,
    output logic grpa_oe,
    output logic grpb_oe
);
    always_comb begin
        wr_grant = fw_wr && !suspended;
        rd_grant = fw_rd_side && !suspended;
        grpa_oe  = !(suspended && cfg_susp_pwroff);
        grpb_oe  = !(suspended && !cfg_board_feat);
    end
endmodule

// File: rtl/susp_seq.sv
module susp_seq
    import susp_seq_pkg::*;
#(
    parameter int unsigned STAB_MIN_MS = 6,
    parameter int unsigned STAB_MAX_MS = 15,
    parameter int unsigned DRIVE_K_MS  = 12,
    parameter int unsigned RWU_MIN_MS  = 7,
    parameter int unsigned STAB_CFG_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_ms,
    input  logic                  bus_suspend,
    input  logic                  host_k,
    input  logic                  rwake_n,
    input  logic                  fw_wr,
    input  logic                  fw_rd_side,
    input  logic                  fw_srst_wr,
    input  logic                  fw_feat_en,
    input  logic                  fw_clr_resume,
    input  logic [STAB_CFG_W-1:0] cfg_stab_ms,
    input  logic                  cfg_irq_en,
    input  logic                  cfg_susp_pwroff,
    input  logic                  cfg_board_feat,
    output logic                  susp_n,
    output logic                  osc_en,
    output logic                  core_clk_en,
    output logic                  resume_flag,
    output logic                  resume_irq,
    output logic                  drive_k,
    output logic                  wr_grant,
    output logic                  rd_grant,
    output logic                  grpa_oe,
    output logic                  grpb_oe
);
    localparam int unsigned CNT_W   = $clog2(max3(STAB_MAX_MS, DRIVE_K_MS, RWU_MIN_MS) + 2);
    localparam logic [CNT_W-1:0] RWU_CNT = CNT_W'(RWU_MIN_MS);
    localparam logic [CNT_W-1:0] K_CNT   = CNT_W'(DRIVE_K_MS);

    seq_state_e       state_q, state_d;
    logic             remote_q;
    logic             flag_q;
    wake_req_t        req;
    wake_src_e        src;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] stab_eff;
    logic             suspended;
    logic             timing;
    logic             hit_stab, hit_rwu, hit_k;
    logic             tmr_clr;

    assign suspended = (state_q == ST_SUSP);
    assign timing    = (state_q == ST_STAB) || (state_q == ST_KHOLD) || (state_q == ST_DRIVEK);
    assign stab_eff  = CNT_W'(clamp_ms(32'(cfg_stab_ms), STAB_MIN_MS, STAB_MAX_MS));

    always_comb begin
        req.host   = host_k;
        req.remote = !rwake_n;
        req.fw     = fw_srst_wr && fw_feat_en;
    end

    susp_wake_arb u_arb (
        .req (req),
        .src (src)
    );

    assign tmr_clr = (state_d != state_q) && (state_d != ST_KHOLD);

    susp_ms_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .en      (timing),
        .tick    (tick_ms),
        .cnt_nxt (cnt_nxt)
    );

    assign hit_stab = tick_ms && (cnt_nxt == stab_eff);
    assign hit_rwu  = tick_ms && (cnt_nxt >= RWU_CNT);
    assign hit_k    = tick_ms && (cnt_nxt == K_CNT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:  if (bus_suspend && !flag_q) state_d = ST_SUSP;
            ST_SUSP:   if (src != WK_NONE) state_d = ST_STAB;
            ST_STAB: begin
                if (hit_stab) begin
                    if (!remote_q)                state_d = ST_AWAKE;
                    else if (cnt_nxt >= RWU_CNT)  state_d = ST_DRIVEK;
                    else                          state_d = ST_KHOLD;
                end
            end
            ST_KHOLD:  if (hit_rwu) state_d = ST_DRIVEK;
            ST_DRIVEK: if (hit_k) state_d = ST_AWAKE;
            default:   state_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_AWAKE;
            remote_q <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (suspended && src != WK_NONE) remote_q <= (src == WK_REMOTE);
            if (state_q == ST_STAB && hit_stab)       flag_q <= 1'b1;
            else if (fw_clr_resume && !suspended)     flag_q <= 1'b0;
        end
    end

    always_comb begin
        susp_n      = !suspended;
        osc_en      = !suspended;
        core_clk_en = (state_q == ST_AWAKE) || (state_q == ST_KHOLD) || (state_q == ST_DRIVEK);
        drive_k     = (state_q == ST_DRIVEK);
        resume_flag = flag_q;
        resume_irq  = flag_q && cfg_irq_en;
    end

    susp_pin_gate u_gate (
        .suspended       (suspended),
        .fw_wr           (fw_wr),
        .fw_rd_side      (fw_rd_side),
        .cfg_susp_pwroff (cfg_susp_pwroff),
        .cfg_board_feat  (cfg_board_feat),
        .wr_grant        (wr_grant),
        .rd_grant        (rd_grant),
        .grpa_oe         (grpa_oe),
        .grpb_oe         (grpb_oe)
    );
endmodule

// File: rtl/susp_seq_chk.sv
module susp_seq_chk
    import susp_seq_pkg::*;
#(
    parameter int unsigned DRIVE_K_MS = 12,
    parameter int unsigned RWU_MIN_MS = 7
) (
    input logic       clk,
    input logic       rst,
    input logic       tick_ms,
    input logic       bus_suspend,
    input logic       host_k,
    input logic       rwake_n,
    input logic       fw_srst_wr,
    input logic       fw_feat_en,
    input logic       fw_clr_resume,
    input logic       cfg_susp_pwroff,
    input logic       cfg_board_feat,
    input seq_state_e state_q,
    input logic       susp_n,
    input logic       osc_en,
    input logic       core_clk_en,
    input logic       resume_flag,
    input logic       resume_irq,
    input logic       drive_k,
    input logic       wr_grant,
    input logic       rd_grant,
    input logic       grpa_oe,
    input logic       grpb_oe
);
    localparam logic [7:0] K_LIM = 8'(DRIVE_K_MS);
    localparam logic [7:0] W_LIM = 8'(RWU_MIN_MS);

    logic [7:0] k_run_q;
    logic [7:0] w_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !drive_k)  k_run_q <= '0;
        else if (tick_ms)     k_run_q <= k_run_q + 8'd1;
        if (rst || !susp_n)   w_cnt_q <= '0;
        else if (tick_ms && w_cnt_q != 8'hFF) w_cnt_q <= w_cnt_q + 8'd1;
    end

    AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_AWAKE && bus_suspend && !resume_flag) |=> (!susp_n && !osc_en && !core_clk_en)); // R1
    AST_SUSP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
        !susp_n |-> (!core_clk_en && !osc_en && !drive_k)); // R1
    AST_HOST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (!susp_n && host_k) |=> (susp_n && osc_en && !core_clk_en)); // R2
    AST_FW_NEEDS_FEAT: assert property (@(posedge clk) disable iff (rst)
        (!susp_n && fw_srst_wr && !fw_feat_en && !host_k && rwake_n) |=> !susp_n); // R2
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        resume_irq |-> resume_flag); // R4
    AST_K_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (drive_k && tick_ms) |-> (k_run_q < K_LIM)); // R5
    AST_K_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_k) |-> (w_cnt_q >= W_LIM)); // R5
    AST_K_WITH_CORE: assert property (@(posedge clk) disable iff (rst)
        drive_k |-> core_clk_en); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (resume_flag && !fw_clr_resume) |=> resume_flag); // R7
    AST_FLAG_BLOCKS_SUSP: assert property (@(posedge clk) disable iff (rst)
        resume_flag |-> susp_n); // R7
    AST_GRANTS_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        !susp_n |-> (!wr_grant && !rd_grant)); // R8
    AST_GRPA_TRISTATE: assert property (@(posedge clk) disable iff (rst)
        (!susp_n && cfg_susp_pwroff) |-> !grpa_oe); // R9
    AST_GRPB_TRISTATE: assert property (@(posedge clk) disable iff (rst)
        (!susp_n && !cfg_board_feat) |-> !grpb_oe); // R10
    AST_AWAKE_PINS_ON: assert property (@(posedge clk) disable iff (rst)
        susp_n |-> (grpa_oe && grpb_oe)); // R9
endmodule

bind susp_seq susp_seq_chk #(
    .DRIVE_K_MS (DRIVE_K_MS),
    .RWU_MIN_MS (RWU_MIN_MS)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .tick_ms         (tick_ms),
    .bus_suspend     (bus_suspend),
    .host_k          (host_k),
    .rwake_n         (rwake_n),
    .fw_srst_wr      (fw_srst_wr),
    .fw_feat_en      (fw_feat_en),
    .fw_clr_resume   (fw_clr_resume),
    .cfg_susp_pwroff (cfg_susp_pwroff),
    .cfg_board_feat  (cfg_board_feat),
    .state_q         (state_q),
    .susp_n          (susp_n),
    .osc_en          (osc_en),
    .core_clk_en     (core_clk_en),
    .resume_flag     (resume_flag),
    .resume_irq      (resume_irq),
    .drive_k         (drive_k),
    .wr_grant        (wr_grant),
    .rd_grant        (rd_grant),
    .grpa_oe         (grpa_oe),
    .grpb_oe         (grpb_oe)
);

// File: tb/susp_seq_tb.sv
module susp_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_ms = 1'b0, bus_suspend = 1'b0, host_k = 1'b0, rwake_n = 1'b1;
    logic       fw_wr = 1'b0, fw_rd_side = 1'b0, fw_srst_wr = 1'b0, fw_feat_en = 1'b0;
    logic       fw_clr_resume = 1'b0;
    logic [3:0] cfg_stab_ms = 4'd6;
    logic       cfg_irq_en = 1'b0, cfg_susp_pwroff = 1'b0, cfg_board_feat = 1'b1;
    logic       susp_n, osc_en, core_clk_en, resume_flag, resume_irq, drive_k;
    logic       wr_grant, rd_grant, grpa_oe, grpb_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    susp_seq u_dut (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .bus_suspend(bus_suspend),
        .host_k(host_k), .rwake_n(rwake_n), .fw_wr(fw_wr), .fw_rd_side(fw_rd_side),
        .fw_srst_wr(fw_srst_wr), .fw_feat_en(fw_feat_en), .fw_clr_resume(fw_clr_resume),
        .cfg_stab_ms(cfg_stab_ms), .cfg_irq_en(cfg_irq_en),
        .cfg_susp_pwroff(cfg_susp_pwroff), .cfg_board_feat(cfg_board_feat),
        .susp_n(susp_n), .osc_en(osc_en), .core_clk_en(core_clk_en),
        .resume_flag(resume_flag), .resume_irq(resume_irq), .drive_k(drive_k),
        .wr_grant(wr_grant), .rd_grant(rd_grant), .grpa_oe(grpa_oe), .grpb_oe(grpb_oe)
    );

    // wk = {host, remote, fw}; exp_s = limited settling ticks; exp_k = K expected
    typedef struct packed {
        logic [2:0] wk;
        logic [3:0] stab;
        logic       irq;
        logic [3:0] exp_s;
        logic       exp_k;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{3'b100, 4'd10, 1'b1, 4'd10, 1'b0},
        '{3'b010, 4'd6,  1'b0, 4'd6,  1'b1},
        '{3'b010, 4'd9,  1'b1, 4'd9,  1'b1},
        '{3'b001, 4'd3,  1'b1, 4'd6,  1'b0},
        '{3'b100, 4'd15, 1'b0, 4'd15, 1'b0},
        '{3'b110, 4'd8,  1'b1, 4'd8,  1'b0},
        '{3'b011, 4'd7,  1'b0, 4'd7,  1'b1},
        '{3'b001, 4'd0,  1'b0, 4'd6,  1'b0}
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_cyc();
        tick_ms = 1'b1;
        cyc();
        tick_ms = 1'b0;
    endtask

    task automatic do_reset();
        bus_suspend = 0; host_k = 0; rwake_n = 1; fw_wr = 0; fw_rd_side = 0;
        fw_srst_wr = 0; fw_feat_en = 0; fw_clr_resume = 0; tick_ms = 0;
        rst = 1; cyc(); cyc(); rst = 0; cyc();
    endtask

    task automatic go_suspend();
        bus_suspend = 1; cyc(); bus_suspend = 0;
    endtask

    initial begin
        cyc();
        do_reset();
        // R11 reset state
        chk("R11 susp_n", susp_n, 1);
        chk("R11 osc_en", osc_en, 1);
        chk("R11 core_clk_en", core_clk_en, 1);
        chk("R11 resume_flag", resume_flag, 0);
        chk("R11 resume_irq", resume_irq, 0);
        chk("R11 drive_k", drive_k, 0);
        chk("R11 grpa_oe", grpa_oe, 1);
        chk("R11 grpb_oe", grpb_oe, 1);

        // vector table: wake source, settling, priority, K length
        for (int i = 0; i < NVEC; i++) begin
            int kseen;
            do_reset();
            cfg_stab_ms = VEC[i].stab;
            cfg_irq_en  = VEC[i].irq;
            go_suspend();
            chk("R1 susp_n low", susp_n, 0);
            chk("R1 core off", core_clk_en, 0);
            host_k     = VEC[i].wk[2];
            rwake_n    = !VEC[i].wk[1];
            fw_srst_wr = VEC[i].wk[0];
            fw_feat_en = 1'b1;
            cyc();
            host_k = 0; rwake_n = 1; fw_srst_wr = 0; fw_feat_en = 0;
            chk("R2 susp_n high", susp_n, 1);
            chk("R2 osc_en", osc_en, 1);
            chk("R2 core still off", core_clk_en, 0);
            for (int t = 1; t < int'(VEC[i].exp_s); t++) begin
                tick_cyc();
                chk("R3 core off during settling", core_clk_en, 0);
            end
            tick_cyc();
            chk("R3 core on at limit", core_clk_en, 1);
            chk("R4 resume_flag", resume_flag, 1);
            chk("R4 resume_irq", resume_irq, int'(VEC[i].irq));
            if (VEC[i].exp_k) begin
                if (VEC[i].exp_s < 4'd7) begin
                    chk("R5 hold before K", drive_k, 0);
                    tick_cyc();
                end
                chk("R5 K starts", drive_k, 1);
                for (int t = 1; t < 12; t++) begin
                    tick_cyc();
                    chk("R5 K held", drive_k, 1);
                end
                tick_cyc();
                chk("R5 K ends after 12", drive_k, 0);
            end else begin
                kseen = int'(drive_k);
                for (int t = 0; t < 14; t++) begin
                    tick_cyc();
                    kseen += int'(drive_k);
                end
                chk("R6 no K for non-remote winner", kseen, 0);
            end
        end

        // R7 flag blocks suspend until cleared
        do_reset();
        cfg_stab_ms = 4'd6;
        go_suspend();
        host_k = 1; cyc(); host_k = 0;
        for (int t = 0; t < 6; t++) tick_cyc();
        chk("R7 flag set", resume_flag, 1);
        for (int t = 0; t < 3; t++) tick_cyc();
        chk("R7 flag held", resume_flag, 1);
        go_suspend();
        chk("R7 suspend blocked", susp_n, 1);
        fw_clr_resume = 1; cyc(); fw_clr_resume = 0;
        chk("R7 flag cleared", resume_flag, 0);
        go_suspend();
        chk("R7 suspend after clear", susp_n, 0);

        // R8 grants while suspended and awake
        fw_wr = 1; fw_rd_side = 1; cyc();
        chk("R8 wr blocked", wr_grant, 0);
        chk("R8 rd blocked", rd_grant, 0);

        // R2 firmware wake without feature bit is ignored
        fw_wr = 0; fw_rd_side = 0;
        fw_srst_wr = 1; fw_feat_en = 0; cyc(); fw_srst_wr = 0;
        chk("R2 fw without feature", susp_n, 0);

        // R9 / R10 tri-state combinations while suspended
        for (int c = 0; c < 4; c++) begin
            cfg_susp_pwroff = c[0];
            cfg_board_feat  = c[1];
            cyc();
            chk("R9 grpa_oe", grpa_oe, int'(!c[0]));
            chk("R10 grpb_oe", grpb_oe, int'(c[1]));
        end

        // R12 suspend ignored during settling
        cfg_stab_ms = 4'd8;
        rwake_n = 0; cyc(); rwake_n = 1;
        for (int t = 0; t < 3; t++) tick_cyc();
        bus_suspend = 1; cyc(); bus_suspend = 0;
        chk("R12 still waking", susp_n, 1);
        chk("R10 pins back on", grpb_oe, 1);
        for (int t = 0; t < 4; t++) tick_cyc();
        chk("R12 core off before 8", core_clk_en, 0);
        tick_cyc();
        chk("R12 core on at 8", core_clk_en, 1);
        fw_wr = 1; fw_rd_side = 1; cyc();
        chk("R8 wr granted awake", wr_grant, 1);
        chk("R8 rd granted awake", rd_grant, 1);
        fw_wr = 0; fw_rd_side = 0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule